// File: doc/BRIEF.md
# Node System-Address to Controller-Address Translator

This block turns a 64-bit system physical address, aimed at one memory node, into the two addresses that node's memory controller works with: the node-local DRAM address and the controller input address. Each request carries its own copy of the node configuration: the DRAM window (base and limit), the memory-hole remap settings (enable, offset, size) and a node-interleave code. Each result is tagged with a flag that says whether the address falls inside the node's window.

The translation runs in two register stages. The first stage checks the window and picks one of two translations. If the address lies in the relocated hole region just above 4 GiB, the hole offset is subtracted from it. Otherwise the node base is subtracted from its low 40 bits. The second stage takes out the node-interleave bits that sit just above the 4 KiB page offset. Both ends of the block are valid/ready streams.

Back-pressure rules are as follows. A request moves in on a cycle where `in_valid` and `in_ready` are both high. A result moves out on a cycle where `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, every output holds steady. The pipeline buffers up to two requests. `in_ready` is high whenever `out_ready` is high. Results leave in the order the requests came in.

Top module: `node_addr_xlat`

## Requirements
- R1: A request is taken on a clock edge where `in_valid` and `in_ready` are both high. With `out_ready` held high, its result shows on the outputs right after the second clock edge that follows. `in_ready` is high whenever `out_ready` is high.
- R2: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_in_range`, `out_dram_addr` and `out_input_addr` stay unchanged. Every accepted request gives exactly one result, and results come out in acceptance order.
- R3: `out_in_range` is 1 exactly when `cfg_base <= in_addr[39:0] <= cfg_limit`. This is an unsigned 40-bit compare with an inclusive limit, and bits 63:40 take no part in it.
- R4: When `cfg_hole_en` is 1 and 0x1_0000_0000 <= `in_addr` < 0x1_0000_0000 + `cfg_hole_size`, `out_dram_addr` = (`in_addr` − `cfg_hole_ofs`) mod 2^40. Both compares use the full 64-bit address, and the upper bound must not wrap at 40 bits.
- R5: Otherwise `out_dram_addr` = (`in_addr[39:0]` − `cfg_base`) mod 2^40. Bits 63:40 of the address are ignored.
- R6: The interleave bit count n comes from `cfg_intlv_code`: code 0 gives 0, code 1 gives 1, code 3 gives 2, code 7 gives 3, and codes 2, 4, 5 and 6 give 0.
- R7: `out_input_addr[11:0]` = `out_dram_addr[11:0]`, and `out_input_addr[35:12]` = `out_dram_addr[35+n:12+n]`.
- R8: When n is 0, `out_input_addr` = `out_dram_addr[35:0]`.
- R9: Each request is translated with the configuration inputs present on the cycle it is accepted. Configuration values on other cycles have no effect on it.
- R10: After reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Block can take a request |
| in_addr | input | 64 | System physical address |
| cfg_base | input | 40 | Node DRAM window base |
| cfg_limit | input | 40 | Node DRAM window limit, inclusive |
| cfg_hole_en | input | 1 | Hole remap enabled |
| cfg_hole_ofs | input | 40 | Value subtracted from addresses in the hole region |
| cfg_hole_size | input | 40 | Size of the relocated region above 4 GiB |
| cfg_intlv_code | input | 3 | Node-interleave enable code |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_in_range | output | 1 | Address lies inside the node window |
| out_dram_addr | output | 40 | Node-local DRAM address |
| out_input_addr | output | 36 | Controller input address |

## Verification
Two situations are the hardest to reach from the ports. One is a full pipeline held by `out_ready` while each queued request carries a different configuration, so that a stale or overwritten configuration would show. The bench drives a random `out_ready` and draws a new random configuration for every request. It drives junk configuration on idle cycles and sends same-address pairs that differ only in configuration. The other is a hole region whose upper bound passes 2^40: a directed request at 2^40 + 5 with a near-maximal hole size must take the hole path, and it would not if the bound wrapped. The hole edges, the window edges and all eight interleave codes are also driven directly.

// File: rtl/node_xlat_pkg.sv
package node_xlat_pkg;

  localparam int unsigned INTLV_CODE_W = 3;
  localparam int unsigned MAX_SHIFT    = 3;
  localparam int unsigned SHIFT_W      = $clog2(MAX_SHIFT + 1);

  // Interleave code to number of address bits removed (R6)
  function automatic logic [SHIFT_W-1:0] intlv_shift(input logic [INTLV_CODE_W-1:0] code);
    logic [SHIFT_W-1:0] n;
    case (code)
      3'd1:    n = SHIFT_W'(1);
      3'd3:    n = SHIFT_W'(2);
      3'd7:    n = SHIFT_W'(3);
      default: n = '0;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/nx_window_check.sv
module nx_window_check #(
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned PHYS_W = 40
) (
  input  logic [ADDR_W-1:0] sys_addr,
  input  logic [PHYS_W-1:0] win_base,
  input  logic [PHYS_W-1:0] win_limit,
  output logic              in_window
);
  logic [PHYS_W-1:0] low_addr;

  always_comb begin
    low_addr  = sys_addr[PHYS_W-1:0];
    in_window = (low_addr >= win_base) && (low_addr <= win_limit);
  end
endmodule

// File: rtl/nx_sys_to_dram.sv
module nx_sys_to_dram #(
  parameter int unsigned ADDR_W   = 64,
  parameter int unsigned PHYS_W   = 40,
  parameter int unsigned HOLE_BIT = 32
) (
  input  logic [ADDR_W-1:0] sys_addr,
  input  logic [PHYS_W-1:0] node_base,
  input  logic              hole_en,
  input  logic [PHYS_W-1:0] hole_ofs,
  input  logic [PHYS_W-1:0] hole_size,
  output logic              hole_hit,
  output logic [PHYS_W-1:0] dram_addr
);
  localparam int unsigned CMP_W = PHYS_W + 1;
  localparam logic [CMP_W-1:0] HOLE_START = CMP_W'(1) << HOLE_BIT;

  logic [CMP_W-1:0] hole_end;
  logic [CMP_W-1:0] addr_cmp;
  logic             upper_clear;

  always_comb begin
    hole_end    = HOLE_START + CMP_W'(hole_size);
    addr_cmp    = sys_addr[CMP_W-1:0];
    upper_clear = ~|sys_addr[ADDR_W-1:CMP_W];
    hole_hit    = hole_en && upper_clear && (addr_cmp >= HOLE_START) && (addr_cmp < hole_end);
    if (hole_hit) dram_addr = sys_addr[PHYS_W-1:0] - hole_ofs;
    else          dram_addr = sys_addr[PHYS_W-1:0] - node_base;
  end
endmodule

// File: rtl/nx_intlv_strip.sv
module nx_intlv_strip
  import node_xlat_pkg::*;
#(
  parameter int unsigned PHYS_W = 40,
  parameter int unsigned IN_W   = 36,
  parameter int unsigned PAGE_W = 12
) (
  input  logic [PHYS_W-1:0]  dram_addr,
  input  logic [SHIFT_W-1:0] shift,
  output logic [IN_W-1:0]    input_addr
);
  localparam int unsigned NEED_W = IN_W + MAX_SHIFT;
  localparam int unsigned EXT_W  = (PHYS_W > NEED_W) ? PHYS_W : NEED_W;

  logic [EXT_W-1:0] dram_ext;
  logic [IN_W-1:0]  cand [MAX_SHIFT+1];

  assign dram_ext = EXT_W'(dram_addr);

  for (genvar k = 0; k <= MAX_SHIFT; k++) begin : g_shift
    assign cand[k] = {dram_ext[k+IN_W-1:k+PAGE_W], dram_addr[PAGE_W-1:0]};
  end

  always_comb begin
    if (int'(shift) <= MAX_SHIFT) input_addr = cand[shift];
    else                          input_addr = cand[0];
  end
endmodule

// File: rtl/nx_pipe_reg.sv
module nx_pipe_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         up_valid,
  output logic         up_ready,
  input  logic [W-1:0] up_data,
  output logic         dn_valid,
  input  logic         dn_ready,
  output logic [W-1:0] dn_data
);
  assign up_ready = !dn_valid || dn_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dn_valid <= 1'b0;
      dn_data  <= '0;
    end else if (up_ready) begin
      dn_valid <= up_valid;
      if (up_valid) dn_data <= up_data;
    end
  end

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (dn_valid && !dn_ready) |=> (dn_valid && $stable(dn_data))) else $error("stall hold"); // R2
  AST_TAKE_VALID: assert property (@(posedge clk) disable iff (!rst_n) (up_valid && up_ready) |=> dn_valid) else $error("take valid"); // R1
endmodule

// File: rtl/node_addr_xlat.sv
module node_addr_xlat
  import node_xlat_pkg::*;
#(
  parameter int unsigned ADDR_W   = 64,
  parameter int unsigned PHYS_W   = 40,
  parameter int unsigned IN_W     = 36,
  parameter int unsigned PAGE_W   = 12,
  parameter int unsigned HOLE_BIT = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [ADDR_W-1:0]       in_addr,
  input  logic [PHYS_W-1:0]       cfg_base,
  input  logic [PHYS_W-1:0]       cfg_limit,
  input  logic                    cfg_hole_en,
  input  logic [PHYS_W-1:0]       cfg_hole_ofs,
  input  logic [PHYS_W-1:0]       cfg_hole_size,
  input  logic [INTLV_CODE_W-1:0] cfg_intlv_code,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic                    out_in_range,
  output logic [PHYS_W-1:0]       out_dram_addr,
  output logic [IN_W-1:0]         out_input_addr
);
  localparam int unsigned S1_W = 1 + SHIFT_W + PHYS_W;
  localparam int unsigned S2_W = S1_W + IN_W;

  // Stage 1: window check, hole or base translation, shift decode
  logic              win_ok;
  logic              hole_hit;
  logic [PHYS_W-1:0] dram_nxt;
  logic [SHIFT_W-1:0] shift_nxt;

  nx_window_check #(.ADDR_W(ADDR_W), .PHYS_W(PHYS_W)) u_win (
    .sys_addr (in_addr),
    .win_base (cfg_base),
    .win_limit(cfg_limit),
    .in_window(win_ok)
  );

  nx_sys_to_dram #(.ADDR_W(ADDR_W), .PHYS_W(PHYS_W), .HOLE_BIT(HOLE_BIT)) u_xlat (
    .sys_addr (in_addr),
    .node_base(cfg_base),
    .hole_en  (cfg_hole_en),
    .hole_ofs (cfg_hole_ofs),
    .hole_size(cfg_hole_size),
    .hole_hit (hole_hit),
    .dram_addr(dram_nxt)
  );

  assign shift_nxt = intlv_shift(cfg_intlv_code);

  logic            s1_valid;
  logic            s1_ready;
  logic [S1_W-1:0] s1_data;

  nx_pipe_reg #(.W(S1_W)) u_stage1 (
    .clk     (clk),
    .rst_n   (rst_n),
    .up_valid(in_valid),
    .up_ready(in_ready),
    .up_data ({win_ok, shift_nxt, dram_nxt}),
    .dn_valid(s1_valid),
    .dn_ready(s1_ready),
    .dn_data (s1_data)
  );

  logic              s1_range;
  logic [SHIFT_W-1:0] s1_shift;
  logic [PHYS_W-1:0] s1_dram;
  assign {s1_range, s1_shift, s1_dram} = s1_data;

  // Stage 2: interleave-bit removal
  logic [IN_W-1:0] input_nxt;

  nx_intlv_strip #(.PHYS_W(PHYS_W), .IN_W(IN_W), .PAGE_W(PAGE_W)) u_strip (
    .dram_addr (s1_dram),
    .shift     (s1_shift),
    .input_addr(input_nxt)
  );

  logic [S2_W-1:0] s2_data;

  nx_pipe_reg #(.W(S2_W)) u_stage2 (
    .clk     (clk),
    .rst_n   (rst_n),
    .up_valid(s1_valid),
    .up_ready(s1_ready),
    .up_data ({s1_data, input_nxt}),
    .dn_valid(out_valid),
    .dn_ready(out_ready),
    .dn_data (s2_data)
  );

  logic [SHIFT_W-1:0] s2_shift;
  assign {out_in_range, s2_shift, out_dram_addr, out_input_addr} = s2_data;

  AST_CODE_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && in_ready && cfg_intlv_code == '0) |=> (s1_shift == '0)) else $error("code zero"); // R6
  AST_PAGE_KEPT: assert property (@(posedge clk) disable iff (!rst_n) out_valid |-> (out_input_addr[PAGE_W-1:0] == out_dram_addr[PAGE_W-1:0])) else $error("page kept"); // R7
  AST_NO_SHIFT_COPY: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && s2_shift == '0) |-> (out_input_addr == out_dram_addr[IN_W-1:0])) else $error("no shift copy"); // R8
  AST_READY_FLOW: assert property (@(posedge clk) disable iff (!rst_n) out_ready |-> in_ready) else $error("ready flow"); // R1
endmodule

// File: tb/node_addr_xlat_tb.sv
`timescale 1ns/1ps
module node_addr_xlat_tb;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n, in_valid, in_ready, out_valid, out_ready;
  logic [63:0] in_addr;
  logic [39:0] cfg_base, cfg_limit, cfg_hole_ofs, cfg_hole_size;
  logic        cfg_hole_en, out_in_range;
  logic [2:0]  cfg_intlv_code;
  logic [39:0] out_dram_addr;
  logic [35:0] out_input_addr;

  node_addr_xlat u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_addr(in_addr),
    .cfg_base(cfg_base), .cfg_limit(cfg_limit), .cfg_hole_en(cfg_hole_en),
    .cfg_hole_ofs(cfg_hole_ofs), .cfg_hole_size(cfg_hole_size), .cfg_intlv_code(cfg_intlv_code),
    .out_valid(out_valid), .out_ready(out_ready), .out_in_range(out_in_range),
    .out_dram_addr(out_dram_addr), .out_input_addr(out_input_addr)
  );

  typedef struct {
    bit [63:0] a; bit [39:0] base, limit, ofs, size; bit hen; bit [2:0] code; string tag;
  } stim_t;
  typedef struct {
    bit inr; bit [39:0] dram; bit [35:0] inp; bit hole; int n; bit [2:0] code; int stamp; string tag;
  } exp_t;

  localparam bit [63:0] HS   = 64'h1_0000_0000;
  localparam bit [63:0] M40  = 64'hFF_FFFF_FFFF;
  localparam int        WD   = 150000;

  stim_t sq[$];
  exp_t  eq[$];
  int n_chk = 0, n_fail = 0, cyc = 0, rdy_pct = 100, fast_since = 0;
  bit stalled = 0, done = 0;
  logic        p_rng;
  logic [39:0] p_dram;
  logic [35:0] p_inp;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  function automatic exp_t model(stim_t s);
    exp_t e;
    bit [63:0] d, t;
    e.inr  = ((s.a & M40) >= {24'h0, s.base}) && ((s.a & M40) <= {24'h0, s.limit});
    e.hole = s.hen && (s.a >= HS) && (s.a < HS + {24'h0, s.size});
    if (e.hole) d = (s.a - {24'h0, s.ofs}) & M40;
    else        d = ((s.a & M40) - {24'h0, s.base}) & M40;
    case (s.code)
      3'd1: e.n = 1;
      3'd3: e.n = 2;
      3'd7: e.n = 3;
      default: e.n = 0;
    endcase
    t = d >> e.n;
    e.dram = d[39:0];
    e.inp  = 36'((t & 64'hF_FFFF_F000) | (d & 64'hFFF));
    e.code = s.code;
    e.tag  = s.tag;
    return e;
  endfunction

  function automatic bit [63:0] r64();
    return {$urandom, $urandom};
  endfunction

  function automatic stim_t mk(bit [63:0] a, bit [39:0] base, bit [39:0] limit, bit hen,
                               bit [39:0] ofs, bit [39:0] size, bit [2:0] code, string tag);
    stim_t s;
    s.a = a; s.base = base; s.limit = limit; s.hen = hen; s.ofs = ofs; s.size = size;
    s.code = code; s.tag = tag;
    return s;
  endfunction

  function automatic stim_t rnd_stim();
    stim_t s;
    bit [39:0] span;
    s.base  = 40'(r64()) & 40'hFF_FFFF_F000;
    span    = 40'({$urandom} % 32'hFFFF_FFFF) << ($urandom_range(6));
    s.limit = s.base + span;
    s.hen   = $urandom_range(3) != 0;
    s.ofs   = 40'(r64());
    s.size  = ($urandom_range(7) == 0) ? 40'(r64()) : 40'($urandom_range(32'h7FFF_FFFF));
    s.code  = 3'($urandom_range(7));
    case ($urandom_range(3))
      0: s.a = HS + 64'(s.size) - 64'd8 + 64'($urandom_range(16));
      1: s.a = HS + 64'($urandom);
      2: s.a = {24'($urandom), s.base + 40'($urandom)};
      default: s.a = r64();
    endcase
    s.tag = "rand";
    return s;
  endfunction

  task automatic run_cycle();
    exp_t e;
    @(negedge clk);
    cyc++;
    out_ready = ($urandom_range(99) < rdy_pct);
    if (sq.size() != 0) begin
      in_valid = 1'b1;
      in_addr = sq[0].a; cfg_base = sq[0].base; cfg_limit = sq[0].limit;
      cfg_hole_en = sq[0].hen; cfg_hole_ofs = sq[0].ofs; cfg_hole_size = sq[0].size;
      cfg_intlv_code = sq[0].code;
    end else begin
      // junk configuration on idle cycles must not reach any result (R9)
      in_valid = 1'b0;
      in_addr = r64(); cfg_base = 40'(r64()); cfg_limit = 40'(r64());
      cfg_hole_en = 1'($urandom); cfg_hole_ofs = 40'(r64()); cfg_hole_size = 40'(r64());
      cfg_intlv_code = 3'($urandom);
    end
    #1;
    if (stalled) begin
      chk(out_valid == 1'b1, "R2 valid held in stall", 64'(out_valid), 64'd1);
      chk(out_in_range == p_rng, "R2 range held in stall", 64'(out_in_range), 64'(p_rng));
      chk(out_dram_addr == p_dram, "R2 dram held in stall", 64'(out_dram_addr), 64'(p_dram));
      chk(out_input_addr == p_inp, "R2 input held in stall", 64'(out_input_addr), 64'(p_inp));
    end
    if (out_ready) chk(in_ready == 1'b1, "R1 ready with out_ready", 64'(in_ready), 64'd1);
    if (out_valid && out_ready) begin
      if (eq.size() == 0) begin
        chk(1'b0, "R2 result without request", 64'd1, 64'd0);
      end else begin
        e = eq.pop_front();
        chk(out_in_range == e.inr, {"R3 in-range ", e.tag}, 64'(out_in_range), 64'(e.inr));
        chk(out_dram_addr == e.dram, {(e.hole ? "R4" : "R5"), " dram ", e.tag},
            64'(out_dram_addr), 64'(e.dram));
        chk(out_input_addr == e.inp,
            {(e.n == 0 ? "R8" : "R7"), ((e.n == 0 && e.code != 0) ? " R6" : ""), " input ", e.tag},
            64'(out_input_addr), 64'(e.inp));
        if (e.stamp > fast_since)
          chk(cyc - e.stamp == 2, "R1 latency", 64'(cyc - e.stamp), 64'd2);
      end
    end
    if (in_valid && in_ready) begin
      e = model(sq[0]);
      e.stamp = cyc;
      eq.push_back(e);
      void'(sq.pop_front());
    end
    stalled = out_valid && !out_ready;
    p_rng = out_in_range; p_dram = out_dram_addr; p_inp = out_input_addr;
  endtask

  task automatic drain();
    int guard = 0;
    while ((sq.size() != 0 || eq.size() != 0) && guard < 5000) begin
      run_cycle();
      guard++;
    end
    chk(eq.size() == 0 && sq.size() == 0, "R2 all results delivered", 64'(eq.size()), 64'd0);
  endtask

  task automatic set_rate(int pct);
    rdy_pct = pct;
    fast_since = (pct == 100) ? cyc : 32'h7FFF_FFFF;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      if (cyc > WD) begin
        n_fail++;
        $display("FAIL watchdog expired at cycle %0d", cyc);
        finish_up();
      end
    end
  end

  initial begin
    bit [39:0] b, l, o, z;
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0; in_addr = '0;
    cfg_base = '0; cfg_limit = '0; cfg_hole_en = 1'b0; cfg_hole_ofs = '0;
    cfg_hole_size = '0; cfg_intlv_code = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(out_valid == 1'b0, "R10 out_valid after reset", 64'(out_valid), 64'd0);
    chk(in_ready == 1'b1, "R10 in_ready after reset", 64'(in_ready), 64'd1);

    b = 40'h02_0000_0000; l = 40'h05_FFFF_FFFF; o = 40'h00_4000_0000; z = 40'h00_4000_0000;
    set_rate(100);
    // hole edges (R4/R5)
    sq.push_back(mk(HS,                b, l, 1, o, z, 0, "hole start"));
    sq.push_back(mk(HS + 64'(z) - 1,   b, l, 1, o, z, 0, "hole last"));
    sq.push_back(mk(HS + 64'(z),       b, l, 1, o, z, 0, "hole end"));
    sq.push_back(mk(HS - 1,            b, l, 1, o, z, 0, "below hole"));
    sq.push_back(mk(HS,                b, l, 0, o, z, 0, "hole disabled"));
    sq.push_back(mk(HS | (64'd1 << 41), b, l, 1, o, z, 0, "bit41 set"));
    sq.push_back(mk(HS,                b, l, 1, o, 40'd0, 0, "empty hole"));
    sq.push_back(mk(64'h100_0000_0005, b, l, 1, o, 40'hFF_FFFF_FFFF, 0, "wide hole R4"));
    // window edges and discarded upper bits (R3/R5)
    sq.push_back(mk({24'hFFFFFF, b},   b, l, 0, o, z, 0, "upper bits at base"));
    sq.push_back(mk(64'(l),            b, l, 0, o, z, 0, "at limit"));
    sq.push_back(mk(64'(l) + 1,        b, l, 0, o, z, 0, "above limit"));
    sq.push_back(mk(64'(b) - 1,        b, l, 0, o, z, 0, "below base"));
    // every interleave code (R6/R7/R8)
    for (int c = 0; c < 8; c++)
      sq.push_back(mk(64'h0A_5A5A_5ABC + 64'(b), b, 40'hFF_FFFF_FFFF, 0, o, z, 3'(c), "code sweep"));
    // same address, configuration differs per request (R9)
    sq.push_back(mk(64'h3_0000_1234, 40'h1_0000_0000, l, 0, o, z, 1, "R9 cfg A"));
    sq.push_back(mk(64'h3_0000_1234, 40'h2_0000_0000, l, 0, o, z, 7, "R9 cfg B"));
    sq.push_back(mk(64'h3_0000_1234, 40'h0_0000_0000, l, 1, 40'h1_0000, 40'h3_0000_0000, 3, "R9 cfg C"));
    drain();

    // back-pressure with random configuration per request (R2/R9)
    set_rate(40);
    for (int i = 0; i < 600; i++) sq.push_back(rnd_stim());
    drain();
    set_rate(100);
    for (int i = 0; i < 400; i++) sq.push_back(rnd_stim());
    drain();
    set_rate(75);
    for (int i = 0; i < 600; i++) sq.push_back(rnd_stim());
    drain();
    finish_up();
  end
endmodule